// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Address Translator

This block takes a linear byte offset inside a tiled surface and produces the address that must be presented to memory when two channels interleave on 64-byte boundaries. The translation flips address bit 6 by XOR-folding a selection of higher bits (9, 10, 11 and 17) into it. Every other bit passes straight through. A small decoder picks which bits are folded in. It looks at the memory-configuration inputs and at the tiling layout of the request, which is linear, X-major or Y-major.

Requests arrive on a valid/ready port together with the configuration that applies to them. The translated address, a 3-bit code naming the active fold and a "tiling not allowed" flag come out of a single output register, one cycle after the request is accepted. That register keeps its value while the consumer stalls.

The configuration comes from one of two sources, chosen by `cfg_by_size`:
- **Addressing-mode word.** The decoder reads the channel mode, the randomisation-disable bit and the bit-17 select from `cfg_word`.
- **Channel sizes.** The decoder compares `cfg_size_a` with `cfg_size_b`.

The decoder reduces the configuration to one of five classes: PLAIN, BASE, XOR11, XOR17 and UNKNOWN.

The output stage is a two-state machine:

| Transition | From | To | Condition |
|---|---|---|---|
| accept | EMPTY | FULL | a request is taken |
| refill | FULL | FULL | the result leaves and a new request is taken in the same cycle |
| stall | FULL | FULL | the consumer does not take the result |
| drain | FULL | EMPTY | the result leaves and no new request is taken |

Top module: `chan_swizzle_xlate`

## Requirements
- R1: Reset state. While `rst_n` is low and after it is released, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Handshake timing.
  - A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1.
  - Its result is shown on `rsp_*` with `rsp_valid`=1 from that edge on.
  - `req_ready` is 1 when the output register is empty or when `rsp_ready` is 1, which allows one request per cycle.
- R3: While `rsp_valid`=1 and `rsp_ready`=0, the next cycle still has `rsp_valid`=1 with `rsp_addr`, `rsp_mode` and `rsp_no_tile` unchanged.
- R4: Every bit of `rsp_addr` other than bit 6 equals the same bit of the accepted `req_addr`.
- R5: A request whose `req_tile` is 0 (linear) or 3 (spare, handled as linear) is never swizzled: `rsp_addr` equals `req_addr` and `rsp_mode` is 0 (none).
- R6: In addressing-mode-word operation, any of the following configurations gives no swizzle (mode 0) for X (`req_tile`=1) and Y (`req_tile`=2) requests, with the flag at 0. The channel mode is `cfg_word[1:0]`.
  - 0, single channel.
  - 1, uneven dual channel.
  - 3, spare.
- R7: With `cfg_word[1:0]`=2 (interleaved) and `cfg_word[2]`=1 (randomisation disabled):
  - X folds bits 9 and 10 into bit 6 (mode 2).
  - Y folds bit 9 (mode 1).
- R8: With interleaved mode, `cfg_word[2]`=0 and `cfg_word[3]`=0:
  - X folds bits 9, 10 and 11 (mode 4).
  - Y folds bits 9 and 11 (mode 3).
  - The flag is 0.
- R9: With interleaved mode, `cfg_word[2]`=0 and `cfg_word[3]`=1:
  - X folds bits 9, 10 and 17 (mode 6).
  - Y folds bits 9 and 17 (mode 5).
  - `rsp_no_tile` is 1 for every request.
- R10: A `cfg_word` of all ones (with `cfg_by_size`=0) means an unknown configuration:
  - `rsp_no_tile` is 1.
  - Tiled requests report mode 7 and pass through unswizzled.
  - Linear requests report mode 0.
- R11: With `cfg_by_size`=1, `cfg_word` is ignored and the flag is 0.
  - If the two channel sizes are equal, X gets mode 2 (bits 9, 10) and Y gets mode 1 (bit 9).
  - If they differ, mode 0 with no swizzle applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | AW | Linear byte offset to translate |
| req_tile | input | 2 | Layout: 0 linear, 1 X, 2 Y, 3 spare (handled as linear) |
| cfg_word | input | CFG_W | Addressing-mode word: [1:0] channel mode, [2] randomisation disable, [3] bit-17 select |
| cfg_by_size | input | 1 | 1 selects the channel-size comparison instead of the word |
| cfg_size_a | input | SZ_W | Population size of channel A |
| cfg_size_b | input | SZ_W | Population size of channel B |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_addr | output | AW | Translated address |
| rsp_mode | output | 3 | Fold code: 0 none, 1 b9, 2 b9+10, 3 b9+11, 4 b9+10+11, 5 b9+17, 6 b9+10+17, 7 unknown |
| rsp_no_tile | output | 1 | Tiling must not be used with this configuration |

## Verification
The bench sweeps every combination of bits 6, 9, 10, 11 and 17 through each configuration class and each layout.
- A design that picked the wrong source bit, or that swapped the X and Y fold sets, gives a wrong bit 6 on exactly the patterns where that bit differs.
- A design that let the all-ones word fall into the spare-channel decode would miss both the unknown code and the flag.
- A design that applied the fold to linear or spare-layout requests would flip bit 6.

A consumer stall pattern is run against back-to-back requests. A stage that overwrote its held result, or dropped or duplicated one, breaks either the hold check or the in-order scoreboard.

// File: rtl/chan_swizzle_pkg.sv
package chan_swizzle_pkg;

    // request layout
    typedef enum logic [1:0] {
        TILE_LINEAR = 2'd0,
        TILE_X      = 2'd1,
        TILE_Y      = 2'd2,
        TILE_SPARE  = 2'd3
    } tile_e;

    // channel mode field of the configuration word
    typedef enum logic [1:0] {
        CH_SINGLE      = 2'd0,
        CH_UNEVEN      = 2'd1,
        CH_INTERLEAVED = 2'd2,
        CH_SPARE       = 2'd3
    } chan_e;

    // reduced configuration class
    typedef enum logic [2:0] {
        CLS_PLAIN   = 3'd0,
        CLS_BASE    = 3'd1,
        CLS_XOR11   = 3'd2,
        CLS_XOR17   = 3'd3,
        CLS_UNKNOWN = 3'd4
    } cfg_cls_e;

    // reported fold code
    typedef enum logic [2:0] {
        SWZ_NONE     = 3'd0,
        SWZ_B9       = 3'd1,
        SWZ_B9_10    = 3'd2,
        SWZ_B9_11    = 3'd3,
        SWZ_B9_10_11 = 3'd4,
        SWZ_B9_17    = 3'd5,
        SWZ_B9_10_17 = 3'd6,
        SWZ_UNKNOWN  = 3'd7
    } swz_e;

    // configuration word field positions
    localparam int CH_LSB      = 0;
    localparam int CH_MSB      = 1;
    localparam int XOR_OFF_BIT = 2;
    localparam int XOR_B17_BIT = 3;

    // address bit that receives the fold
    localparam int TARGET_BIT = 6;

    typedef struct packed {
        logic use9;
        logic use10;
        logic use11;
        logic use17;
    } fold_t;

    function automatic fold_t fold_of(input swz_e m);
        fold_t f;
        f = '0;
        unique case (m)
            SWZ_B9:       f = '{use9: 1'b1, use10: 1'b0, use11: 1'b0, use17: 1'b0};
            SWZ_B9_10:    f = '{use9: 1'b1, use10: 1'b1, use11: 1'b0, use17: 1'b0};
            SWZ_B9_11:    f = '{use9: 1'b1, use10: 1'b0, use11: 1'b1, use17: 1'b0};
            SWZ_B9_10_11: f = '{use9: 1'b1, use10: 1'b1, use11: 1'b1, use17: 1'b0};
            SWZ_B9_17:    f = '{use9: 1'b1, use10: 1'b0, use11: 1'b0, use17: 1'b1};
            SWZ_B9_10_17: f = '{use9: 1'b1, use10: 1'b1, use11: 1'b0, use17: 1'b1};
            default:      f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
    import chan_swizzle_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter int SZ_W  = 16
) (
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             cfg_by_size,
    input  logic [SZ_W-1:0]  size_a,
    input  logic [SZ_W-1:0]  size_b,
    output cfg_cls_e         cls
);

    localparam logic [CFG_W-1:0] ALL_ONES = {CFG_W{1'b1}};

    chan_e ch_mode;
    logic  xor_off;
    logic  xor_b17;

    assign ch_mode = chan_e'(cfg_word[CH_MSB:CH_LSB]);
    assign xor_off = cfg_word[XOR_OFF_BIT];
    assign xor_b17 = cfg_word[XOR_B17_BIT];

    always_comb begin
        cls = CLS_PLAIN;
        if (cfg_by_size) begin
            cls = (size_a == size_b) ? CLS_BASE : CLS_PLAIN;
        end else if (cfg_word == ALL_ONES) begin
            cls = CLS_UNKNOWN;
        end else begin
            unique case (ch_mode)
                CH_INTERLEAVED: begin
                    if (xor_off)
                        cls = CLS_BASE;
                    else if (xor_b17)
                        cls = CLS_XOR17;
                    else
                        cls = CLS_XOR11;
                end
                default: cls = CLS_PLAIN;
            endcase
        end
    end

endmodule

// File: rtl/swz_addr_remap.sv
module swz_addr_remap
    import chan_swizzle_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_in,
    input  tile_e         tile,
    input  cfg_cls_e      cls,
    output logic [AW-1:0] addr_out,
    output swz_e          mode,
    output logic          no_tile
);

    logic a9, a10, a11, a17;
    logic flip;
    fold_t fold;

    assign a9  = addr_in[9];
    assign a10 = addr_in[10];

    generate
        if (AW > 11) begin : g_b11
            assign a11 = addr_in[11];
        end else begin : g_no_b11
            assign a11 = 1'b0;
        end
        if (AW > 17) begin : g_b17
            assign a17 = addr_in[17];
        end else begin : g_no_b17
            assign a17 = 1'b0;
        end
    endgenerate

    always_comb begin
        mode = SWZ_NONE;
        unique case (tile)
            TILE_X: begin
                unique case (cls)
                    CLS_BASE:    mode = SWZ_B9_10;
                    CLS_XOR11:   mode = SWZ_B9_10_11;
                    CLS_XOR17:   mode = SWZ_B9_10_17;
                    CLS_UNKNOWN: mode = SWZ_UNKNOWN;
                    default:     mode = SWZ_NONE;
                endcase
            end
            TILE_Y: begin
                unique case (cls)
                    CLS_BASE:    mode = SWZ_B9;
                    CLS_XOR11:   mode = SWZ_B9_11;
                    CLS_XOR17:   mode = SWZ_B9_17;
                    CLS_UNKNOWN: mode = SWZ_UNKNOWN;
                    default:     mode = SWZ_NONE;
                endcase
            end
            default: mode = SWZ_NONE;
        endcase
    end

    assign fold = fold_of(mode);
    assign flip = (fold.use9 & a9) ^ (fold.use10 & a10) ^
                  (fold.use11 & a11) ^ (fold.use17 & a17);

    always_comb begin
        addr_out             = addr_in;
        addr_out[TARGET_BIT] = addr_in[TARGET_BIT] ^ flip;
    end

    assign no_tile = (cls == CLS_UNKNOWN) || (cls == CLS_XOR17);

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_e;

    stage_e        state_q, state_d;
    logic [DW-1:0] data_q;
    logic          take;
    logic          drain;

    assign take  = in_valid && in_ready;
    assign drain = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (take) state_d = ST_FULL;
            ST_FULL:  if (drain && !take) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
        out_data  = data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (take)
            data_q <= in_data;
    end

endmodule

// File: rtl/chan_swizzle_xlate.sv
module chan_swizzle_xlate
    import chan_swizzle_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CFG_W = 32,
    parameter int SZ_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_tile,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             cfg_by_size,
    input  logic [SZ_W-1:0]  cfg_size_a,
    input  logic [SZ_W-1:0]  cfg_size_b,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [AW-1:0]    rsp_addr,
    output logic [2:0]       rsp_mode,
    output logic             rsp_no_tile
);

    localparam int DW = AW + 4;

    cfg_cls_e      cls;
    swz_e          mode;
    logic [AW-1:0] addr_x;
    logic          no_tile;
    logic [DW-1:0] pack_in;
    logic [DW-1:0] pack_out;

    swz_cfg_decode #(.CFG_W(CFG_W), .SZ_W(SZ_W)) u_decode (
        .cfg_word    (cfg_word),
        .cfg_by_size (cfg_by_size),
        .size_a      (cfg_size_a),
        .size_b      (cfg_size_b),
        .cls         (cls)
    );

    swz_addr_remap #(.AW(AW)) u_remap (
        .addr_in  (req_addr),
        .tile     (tile_e'(req_tile)),
        .cls      (cls),
        .addr_out (addr_x),
        .mode     (mode),
        .no_tile  (no_tile)
    );

    assign pack_in = {no_tile, mode, addr_x};

    swz_out_stage #(.DW(DW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   (pack_in),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_data  (pack_out)
    );

    assign rsp_addr    = pack_out[AW-1:0];
    assign rsp_mode    = pack_out[AW+2:AW];
    assign rsp_no_tile = pack_out[AW+3];

endmodule

// File: rtl/swz_xlate_chk.sv
module swz_xlate_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_tile,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic [2:0]    rsp_mode,
    input logic          rsp_no_tile
);

    localparam logic [AW-1:0] KEEP = ~({{(AW-1){1'b0}}, 1'b1} << 6);

    logic [AW-1:0] cap_addr;
    logic [1:0]    cap_tile;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_tile <= 2'd0;
        end else if (req_valid && req_ready) begin
            cap_addr <= req_addr;
            cap_tile <= req_tile;
        end
    end

    p_accept_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                       $stable(rsp_mode) && $stable(rsp_no_tile)));

    p_upper_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (((rsp_addr ^ cap_addr) & KEEP) == '0));

    p_linear_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (cap_tile == 2'd0 || cap_tile == 2'd3)) |->
            (rsp_addr == cap_addr && rsp_mode == 3'd0));

    p_unknown_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_mode == 3'd7) |-> (rsp_no_tile && rsp_addr == cap_addr));

endmodule

bind chan_swizzle_xlate swz_xlate_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_tile    (req_tile),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_addr    (rsp_addr),
    .rsp_mode    (rsp_mode),
    .rsp_no_tile (rsp_no_tile)
);

// File: tb/chan_swizzle_xlate_test.sv
`timescale 1ns/1ps
module chan_swizzle_xlate_test;

    localparam int AW = 32;
    localparam int EW = AW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_tile = 2'd0;
    logic [31:0]   cfg_word = '0;
    logic          cfg_by_size = 1'b0;
    logic [15:0]   cfg_size_a = '0;
    logic [15:0]   cfg_size_b = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [AW-1:0] rsp_addr;
    logic [2:0]    rsp_mode;
    logic          rsp_no_tile;

    int checks = 0;
    int fails  = 0;
    int sent   = 0;
    int got    = 0;
    logic bp_mode = 1'b0;
    int bp_cnt = 0;

    typedef struct {
        logic [EW-1:0] exp;
        string         tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;

    chan_swizzle_xlate #(.AW(AW), .CFG_W(32), .SZ_W(16)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_tile(req_tile),
        .cfg_word(cfg_word), .cfg_by_size(cfg_by_size),
        .cfg_size_a(cfg_size_a), .cfg_size_b(cfg_size_b),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_addr(rsp_addr), .rsp_mode(rsp_mode), .rsp_no_tile(rsp_no_tile)
    );

    // expected result from the requirements
    function automatic logic [EW-1:0] model(input logic [AW-1:0] a, input logic [1:0] t,
                                            input logic [31:0] w, input logic bysz,
                                            input logic [15:0] sa, input logic [15:0] sb_);
        logic [2:0] code;
        logic flag, flip, tiled, isx;
        logic [AW-1:0] o;
        tiled = (t == 2'd1) || (t == 2'd2);
        isx   = (t == 2'd1);
        code  = 3'd0;
        flag  = 1'b0;
        if (bysz) begin
            if (tiled && sa == sb_) code = isx ? 3'd2 : 3'd1;
        end else if (w == 32'hFFFF_FFFF) begin
            flag = 1'b1;
            if (tiled) code = 3'd7;
        end else if (w[1:0] == 2'd2) begin
            if (w[2]) begin
                if (tiled) code = isx ? 3'd2 : 3'd1;
            end else if (w[3]) begin
                flag = 1'b1;
                if (tiled) code = isx ? 3'd6 : 3'd5;
            end else begin
                if (tiled) code = isx ? 3'd4 : 3'd3;
            end
        end
        case (code)
            3'd1: flip = a[9];
            3'd2: flip = a[9] ^ a[10];
            3'd3: flip = a[9] ^ a[11];
            3'd4: flip = a[9] ^ a[10] ^ a[11];
            3'd5: flip = a[9] ^ a[17];
            3'd6: flip = a[9] ^ a[10] ^ a[17];
            default: flip = 1'b0;
        endcase
        o = a;
        o[6] = a[6] ^ flip;
        return {flag, code, o};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [AW-1:0] a, input logic [1:0] t, input logic [31:0] w,
                        input logic bysz, input logic [15:0] sa, input logic [15:0] sb_,
                        input string tag);
        item_t it;
        @(negedge clk);
        req_addr = a; req_tile = t; cfg_word = w;
        cfg_by_size = bysz; cfg_size_a = sa; cfg_size_b = sb_;
        req_valid = 1'b1;
        #2;
        while (!req_ready) begin
            @(negedge clk);
            #2;
        end
        it.exp = model(a, t, w, bysz, sa, sb_);
        it.tag = tag;
        sb.push_back(it);
        sent++;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // monitor: drives consumer readiness, compares popped results, checks holds
    logic          held = 1'b0;
    logic [EW-1:0] held_val;
    initial begin
        forever begin
            @(negedge clk);
            bp_cnt++;
            rsp_ready = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
            #1;
            if (held) begin
                check(rsp_valid && {rsp_no_tile, rsp_mode, rsp_addr} == held_val, "R3 hold",
                      64'({rsp_valid, rsp_no_tile, rsp_mode, rsp_addr}), 64'({1'b1, held_val}));
            end
            held = rsp_valid && !rsp_ready;
            held_val = {rsp_no_tile, rsp_mode, rsp_addr};
            if (rsp_valid && rsp_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R2 unexpected result", 64'(rsp_addr), 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    got++;
                    check({rsp_no_tile, rsp_mode, rsp_addr} == it.exp, it.tag,
                          64'({rsp_no_tile, rsp_mode, rsp_addr}), 64'(it.exp));
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    localparam logic [AW-1:0] BASE = 32'hC3C0_1025;

    function automatic logic [AW-1:0] pat(input int i);
        logic [AW-1:0] a;
        a = BASE;
        a[6]  = i[0];
        a[9]  = i[1];
        a[10] = i[2];
        a[11] = i[3];
        a[17] = i[4];
        return a;
    endfunction

    task automatic sweep(input logic [31:0] w, input logic bysz, input logic [15:0] sa,
                         input logic [15:0] sb_, input string tag);
        for (int i = 0; i < 32; i++) begin
            send(pat(i), 2'd1, w, bysz, sa, sb_, {tag, " X"});
            send(pat(i), 2'd2, w, bysz, sa, sb_, {tag, " Y"});
            send(pat(i), 2'(i % 2 == 0 ? 0 : 3), w, bysz, sa, sb_, {"R5 linear under ", tag});
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1 check(rsp_valid == 1'b0, "R1 valid in reset", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check(rsp_valid == 1'b0, "R1 valid after reset", 64'(rsp_valid), 64'd0);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

        // R2: result appears right after the accepting edge
        send(pat(3), 2'd1, 32'h6, 1'b0, 16'd0, 16'd0, "R2 single");
        @(negedge clk);
        #3 check(rsp_valid == 1'b1, "R2 one cycle latency", 64'(rsp_valid), 64'd1);

        // configuration sweeps, consumer always ready
        sweep(32'h0000_0000, 1'b0, 16'd0, 16'd0, "R6 single");
        sweep(32'h0000_0001, 1'b0, 16'd0, 16'd0, "R6 uneven");
        sweep(32'h0000_000F, 1'b0, 16'd0, 16'd0, "R6 spare");
        sweep(32'h0000_0006, 1'b0, 16'd0, 16'd0, "R7 base");
        sweep(32'h0000_0002, 1'b0, 16'd0, 16'd0, "R8 xor11");
        sweep(32'h0000_000A, 1'b0, 16'd0, 16'd0, "R9 xor17");
        sweep(32'hFFFF_FFFF, 1'b0, 16'd0, 16'd0, "R10 unknown");
        sweep(32'hFFFF_FFFF, 1'b1, 16'h0400, 16'h0400, "R11 equal");
        sweep(32'h0000_000A, 1'b1, 16'h0400, 16'h0200, "R11 unequal");

        // R3: consumer stalls against back-to-back requests
        bp_mode = 1'b1;
        sweep(32'h0000_0002, 1'b0, 16'd0, 16'd0, "R3 stall xor11");
        sweep(32'h0000_000A, 1'b0, 16'd0, 16'd0, "R3 stall xor17");
        bp_mode = 1'b0;

        // drain and account for every request (R2)
        repeat (10) @(negedge clk);
        #3 check(sb.size() == 0 && got == sent, "R2 all results delivered",
                 64'(got), 64'(sent));
        check(rsp_valid == 1'b0, "R2 empty after drain", 64'(rsp_valid), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule